// File: doc/BRIEF.md
# Dual FIFO Occupancy and Interrupt Logic

This block keeps the fill level of two sample FIFOs that sit beside it: a short pre-trigger FIFO that holds one block of conversions (one per channel) and a deep post-trigger FIFO that collects samples after a trigger. It takes one write pulse and one read pulse per FIFO, counts the occupancy of each up and down, and derives status flags from those counts. Either FIFO may be read while it is still being written. A clear command empties both trackers at once.

The two occupancy counts share one 16-bit readback word: the pre-trigger count sits in the low byte and the post-trigger count in the high byte. The high byte shows only the post-trigger count modulo 256, so a quarter-full flag, set when that byte wraps, extends the readable range. The flags then cover quarter, half and full. Three enable inputs pick which conditions drive a level interrupt request. A 16-bit vector is presented while the request is high.

The post-trigger tracker is a state machine with six states. `PS_EMPTY` holds no samples. `PS_FILL` is partly filled before any wrap of the count byte. `PS_QTR` is entered when the byte wraps below half, and it drives the quarter flag. `PS_HALF` covers half full or more. `PS_FULL` is at depth. `PS_TAIL` is below half after half was reached, with the quarter flag cleared. The transitions are: FILL_FROM_EMPTY (a write into an empty FIFO), WRAP_TO_QTR (a byte wrap below half), RISE_TO_HALF (the count reaches half), REACH_FULL (the count reaches depth), LEAVE_FULL (a read at depth), DROP_TO_TAIL (the count falls below half), and DRAIN_TO_EMPTY (the count reaches zero). The clear command forces PS_EMPTY from every state.

Top module: `fifo_occ_irq`

## Requirements
- R1: A write pulse raises the pre-trigger count by one and a read pulse lowers it by one. A write at PRE_DEPTH (16) is ignored, and so is a read at zero. The count appears in bits 7:0 of `fill_word` one cycle after the pulse.
- R2: A write pulse raises the post-trigger count by one and a read pulse lowers it by one. A write at POST_DEPTH (1024) is ignored, and so is a read at zero. Bits 15:8 of `fill_word` show the count modulo 256, one cycle after the pulse.
- R3: When a FIFO gets a write and a read in the same cycle, its count does not change.
- R4: `pre_full` is high exactly when the pre-trigger count equals PRE_DEPTH. `pre_half` is high when the count is at least PRE_DEPTH/2. `pre_empty` is high when the count is zero. A read at full therefore drops `pre_full`.
- R5: `post_half` is high when the post-trigger count is at least POST_DEPTH/2. `post_full` is high when the count equals POST_DEPTH. `post_empty` is high when the count is zero.
- R6: `post_qtr` is set by an accepted post-trigger write that makes the count a non-zero multiple of 256 while the count stays below half. Once set, it holds through any change that keeps the count between 1 and half minus one. It is cleared when the count reaches half or more, or reaches zero.
- R7: `irq` is the OR of (`ie_pre_full` and `pre_full`), (`ie_pre_half` and `pre_half`) and (`ie_post_full` and `post_full`). It stays high while any enabled condition holds. `irq_vector` equals `vector` while `irq` is high and is zero otherwise.
- R8: A cycle with `clr` high brings both counts to zero and sets both empty flags. It also clears every other flag in the next cycle, overriding any write or read in that cycle.
- R9: After reset, `fill_word` is 0, `pre_empty` and `post_empty` are 1, and every other flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of both trackers |
| pre_wr | input | 1 | Pre-trigger FIFO write pulse |
| pre_rd | input | 1 | Pre-trigger FIFO read pulse |
| post_wr | input | 1 | Post-trigger FIFO write pulse |
| post_rd | input | 1 | Post-trigger FIFO read pulse |
| ie_pre_full | input | 1 | Interrupt enable, pre-trigger full |
| ie_pre_half | input | 1 | Interrupt enable, pre-trigger half full |
| ie_post_full | input | 1 | Interrupt enable, post-trigger full |
| vector | input | 16 | Interrupt vector value |
| fill_word | output | 16 | Post count byte (15:8), pre count byte (7:0) |
| pre_full | output | 1 | Pre-trigger FIFO full |
| pre_half | output | 1 | Pre-trigger FIFO half full |
| pre_empty | output | 1 | Pre-trigger FIFO empty |
| post_qtr | output | 1 | Post-trigger quarter flag |
| post_half | output | 1 | Post-trigger half full |
| post_full | output | 1 | Post-trigger full |
| post_empty | output | 1 | Post-trigger empty |
| irq | output | 1 | Level interrupt request |
| irq_vector | output | 16 | Vector while irq is high, else zero |

## Verification
A count that is off by one shows in `fill_word` on the cycle after the bad update and stays visible. A wrong post-trigger state, such as a missed wrap or a missed fall below half, shows on `post_qtr` or `post_half` in the same cycle as the state register. A wrong mask shows on `irq` straight away. The bench keeps its own occupancy model and compares every output on every cycle, so any divergence is reported within one clock of its cause. Long fills to depth and drains back to zero exercise every wrap and every threshold.

// File: rtl/fifo_occ_pkg.sv
package fifo_occ_pkg;
    typedef enum logic [2:0] {
        PS_EMPTY = 3'd0,
        PS_FILL  = 3'd1,
        PS_QTR   = 3'd2,
        PS_HALF  = 3'd3,
        PS_FULL  = 3'd4,
        PS_TAIL  = 3'd5
    } post_state_e;
endpackage

// File: rtl/occ_pre_track.sv
module occ_pre_track #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic          rd,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          half,
    output logic          empty
);
    localparam logic [CW-1:0] TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] MID  = CW'(DEPTH / 2);

    logic inc, dec;

    always_comb begin
        inc = wr && !rd && (cnt != TOP);
        dec = rd && !wr && (cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    always_comb begin
        full  = (cnt == TOP);
        half  = (cnt >= MID);
        empty = (cnt == '0);
    end

    // R1
    pre_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    // R3
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rd && !clr) |=> $stable(cnt));
endmodule

// File: rtl/occ_post_track.sv
module occ_post_track
    import fifo_occ_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int BW    = 8,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic          rd,
    output logic [CW-1:0] cnt,
    output logic          qtr,
    output logic          half,
    output logic          full,
    output logic          empty
);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);
    localparam logic [CW-1:0] MID = CW'(DEPTH / 2);

    post_state_e   state, state_nxt;
    logic          inc, dec, wrap;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        inc     = wr && !rd && (cnt != TOP);
        dec     = rd && !wr && (cnt != '0);
        wrap    = inc && (cnt[BW-1:0] == {BW{1'b1}});
        cnt_nxt = inc ? cnt + 1'b1 : (dec ? cnt - 1'b1 : cnt);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_EMPTY: if (inc) state_nxt = PS_FILL;
            PS_FILL, PS_TAIL: begin
                if (cnt_nxt == '0)       state_nxt = PS_EMPTY;
                else if (cnt_nxt >= MID) state_nxt = PS_HALF;
                else if (wrap)           state_nxt = PS_QTR;
            end
            PS_QTR: begin
                if (cnt_nxt == '0)       state_nxt = PS_EMPTY;
                else if (cnt_nxt >= MID) state_nxt = PS_HALF;
            end
            PS_HALF: begin
                if (cnt_nxt == TOP)      state_nxt = PS_FULL;
                else if (cnt_nxt < MID)  state_nxt = PS_TAIL;
            end
            PS_FULL: if (dec) state_nxt = PS_HALF;
            default: state_nxt = PS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_EMPTY;
            cnt   <= '0;
        end else if (clr) begin
            state <= PS_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        qtr   = (state == PS_QTR);
        half  = (state == PS_HALF) || (state == PS_FULL);
        full  = (state == PS_FULL);
        empty = (state == PS_EMPTY);
    end

    // R2
    post_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    // R5
    post_full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (cnt == TOP));

    // R5
    post_empty_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (cnt == '0));

    // R6
    qtr_below_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qtr |-> (cnt < MID) && (cnt != '0));
endmodule

// File: rtl/occ_irq_mask.sv
module occ_irq_mask #(
    parameter int VW = 16
) (
    input  logic          pre_full,
    input  logic          pre_half,
    input  logic          post_full,
    input  logic          ie_pre_full,
    input  logic          ie_pre_half,
    input  logic          ie_post_full,
    input  logic [VW-1:0] vector,
    output logic          irq,
    output logic [VW-1:0] irq_vector
);
    always_comb begin
        irq        = (ie_pre_full && pre_full) || (ie_pre_half && pre_half)
                   || (ie_post_full && post_full);
        irq_vector = irq ? vector : '0;
    end
endmodule

// File: rtl/fifo_occ_irq.sv
module fifo_occ_irq #(
    parameter int PRE_DEPTH  = 16,
    parameter int POST_DEPTH = 1024,
    parameter int BW         = 8,
    parameter int VW         = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            pre_wr,
    input  logic            pre_rd,
    input  logic            post_wr,
    input  logic            post_rd,
    input  logic            ie_pre_full,
    input  logic            ie_pre_half,
    input  logic            ie_post_full,
    input  logic [VW-1:0]   vector,
    output logic [2*BW-1:0] fill_word,
    output logic            pre_full,
    output logic            pre_half,
    output logic            pre_empty,
    output logic            post_qtr,
    output logic            post_half,
    output logic            post_full,
    output logic            post_empty,
    output logic            irq,
    output logic [VW-1:0]   irq_vector
);
    localparam int PRE_CW  = $clog2(PRE_DEPTH) + 1;
    localparam int POST_CW = $clog2(POST_DEPTH) + 1;

    logic [PRE_CW-1:0]  pre_cnt;
    logic [POST_CW-1:0] post_cnt;

    occ_pre_track #(.DEPTH(PRE_DEPTH), .CW(PRE_CW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr(pre_wr), .rd(pre_rd),
        .cnt(pre_cnt), .full(pre_full), .half(pre_half), .empty(pre_empty)
    );

    occ_post_track #(.DEPTH(POST_DEPTH), .BW(BW), .CW(POST_CW)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr(post_wr), .rd(post_rd),
        .cnt(post_cnt), .qtr(post_qtr), .half(post_half), .full(post_full),
        .empty(post_empty)
    );

    occ_irq_mask #(.VW(VW)) u_irq (
        .pre_full(pre_full), .pre_half(pre_half), .post_full(post_full),
        .ie_pre_full(ie_pre_full), .ie_pre_half(ie_pre_half),
        .ie_post_full(ie_post_full), .vector(vector),
        .irq(irq), .irq_vector(irq_vector)
    );

    always_comb begin
        fill_word = {post_cnt[BW-1:0], BW'(pre_cnt)};
    end

    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill_word == '0) && pre_empty && post_empty && !irq);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pre_full || pre_half || post_full));
endmodule

// File: tb/sim_fifo_occ_irq.sv
module sim_fifo_occ_irq;
    localparam int CLK_NS = 10;
    localparam int PRE    = 16;
    localparam int POST   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 0, pre_wr = 0, pre_rd = 0, post_wr = 0, post_rd = 0;
    logic        ie_pf = 0, ie_ph = 0, ie_tf = 0;
    logic [15:0] vector = 16'h0;
    logic [15:0] fill_word, irq_vector;
    logic        pre_full, pre_half, pre_empty;
    logic        post_qtr, post_half, post_full, post_empty, irq;

    int n_chk = 0;
    int n_fail = 0;
    int m_pre = 0, m_post = 0;
    bit m_qf = 0;

    always #(CLK_NS/2) clk = ~clk;

    fifo_occ_irq u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pre_wr(pre_wr), .pre_rd(pre_rd),
        .post_wr(post_wr), .post_rd(post_rd), .ie_pre_full(ie_pf),
        .ie_pre_half(ie_ph), .ie_post_full(ie_tf), .vector(vector),
        .fill_word(fill_word), .pre_full(pre_full), .pre_half(pre_half),
        .pre_empty(pre_empty), .post_qtr(post_qtr), .post_half(post_half),
        .post_full(post_full), .post_empty(post_empty), .irq(irq),
        .irq_vector(irq_vector)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int nxt;
        bit wrap;
        if (clr) begin
            m_pre = 0; m_post = 0; m_qf = 0;
            return;
        end
        if (pre_wr && !pre_rd && m_pre < PRE) m_pre++;
        else if (pre_rd && !pre_wr && m_pre > 0) m_pre--;
        nxt  = m_post;
        wrap = 0;
        if (post_wr && !post_rd && m_post < POST) begin
            nxt++;
            wrap = (nxt % 256) == 0;
        end else if (post_rd && !post_wr && m_post > 0) nxt--;
        if (nxt == 0 || nxt >= POST/2) m_qf = 0;
        else if (wrap) m_qf = 1;
        m_post = nxt;
    endtask

    task automatic compare_all();
        bit e_irq;
        e_irq = (ie_pf && m_pre == PRE) || (ie_ph && m_pre >= PRE/2)
              || (ie_tf && m_post == POST);
        chk("R1 pre count byte", fill_word[7:0], m_pre);
        chk("R2 post count byte", fill_word[15:8], m_post % 256);
        chk("R4 pre_full", pre_full, m_pre == PRE);
        chk("R4 pre_half", pre_half, m_pre >= PRE/2);
        chk("R4 pre_empty", pre_empty, m_pre == 0);
        chk("R5 post_half", post_half, m_post >= POST/2);
        chk("R5 post_full", post_full, m_post == POST);
        chk("R5 post_empty", post_empty, m_post == 0);
        chk("R6 post_qtr", post_qtr, m_qf);
        chk("R7 irq", irq, e_irq);
        chk("R7 irq_vector", irq_vector, e_irq ? vector : 16'h0);
    endtask

    // inputs change at negedge, model at posedge, compare at next negedge
    task automatic cyc(bit pw, bit pr, bit qw, bit qr, bit c);
        pre_wr = pw; pre_rd = pr; post_wr = qw; post_rd = qr; clr = c;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rnd_cycles(int n, int qw_pct, int qr_pct);
        for (int i = 0; i < n; i++) begin
            if (i % 37 == 0) begin
                {ie_pf, ie_ph, ie_tf} = 3'($urandom);
                vector = 16'($urandom);
            end
            cyc($urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(1, 100) <= qw_pct, $urandom_range(1, 100) <= qr_pct, 1'b0);
        end
    endtask

    initial begin
        logic [15:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 fill_word", fill_word, 0);
        chk("R9 empties", {pre_empty, post_empty}, 2'b11);
        chk("R9 other flags", {pre_full, pre_half, post_qtr, post_half, post_full, irq}, 0);
        // R1 ignored read at empty, then overfill pre
        cyc(0, 1, 0, 1, 0);
        chk("R1 read at empty ignored", fill_word, 0);
        ie_pf = 1; vector = 16'hBEEF;
        for (int i = 0; i < PRE + 3; i++) cyc(1, 0, 0, 0, 0);
        chk("R1 write at full ignored", fill_word[7:0], PRE);
        chk("R7 vector on pre full", irq_vector, 16'hBEEF);
        cyc(0, 1, 0, 0, 0);
        chk("R4 read clears pre_full", pre_full, 0);
        rnd_cycles(300, 50, 50);
        // fill post to depth and beyond
        ie_tf = 1;
        for (int i = 0; i < POST + 20; i++) cyc(0, 0, 1, 0, 0);
        chk("R2 write at full ignored", post_full, 1);
        rnd_cycles(1200, 90, 15);
        rnd_cycles(1300, 10, 90);
        rnd_cycles(1500, 70, 30);
        rnd_cycles(1500, 35, 65);
        rnd_cycles(1500, 55, 45);
        // R3 simultaneous write and read
        snap = fill_word;
        cyc(1, 1, 1, 1, 0);
        chk("R3 simultaneous hold", fill_word, snap);
        // R8 clear overrides traffic
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 1);
        chk("R8 clear counts", fill_word, 0);
        chk("R8 clear empties", {pre_empty, post_empty}, 2'b11);
        rnd_cycles(200, 60, 40);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule